// File: doc/BRIEF.md
# External interrupt request conditioner

This block sits between two external active-low interrupt request pins and an interrupt controller. Each pin is brought into the clock domain through a short synchronizer chain. It then becomes one pending request line. A per-pin sensitivity control picks how the pin is interpreted. Level sensitivity makes the request track the inverted pin. Falling-edge sensitivity latches the request until software acknowledges it with a clear pulse.

When the system is in a low-power stop or wait state, every pin is treated as level-sensitive whatever its control bit holds. A pin held low can therefore wake the system. A small register view reports the synchronized pin levels next to the sensitivity bits. The block also produces a reset-vector-valid signal for the core's reset handshake. This signal is high throughout reset and for a fixed number of rising edges after reset is released.

All interfaces are plain control and status pins. There is no data stream and no back-pressure. The register write strobe takes effect on the next rising edge, and the read data is always valid.

Top module: `xirq_cond`

## Requirements
- R1: After reset both sensitivity bits are 0 (level mode), reg_rdata[1:0] reads 0, and with both pins high both pending outputs are 0.
- R2: reg_rdata bit 3 shows the synchronized level of pin B (index 1) and bit 2 shows pin A (index 0). Bit 1 is the sensitivity bit of pin B and bit 0 is that of pin A. A pin change appears in the status bits two rising edges after it is sampled.
- R3: In level mode (sensitivity bit 0), pend equals the inverted synchronized pin level and is not latched: it drops when the pin returns high.
- R4: In edge mode (sensitivity bit 1), a falling edge on the synchronized pin sets pend. Pend stays set after the pin returns high, until a clear pulse on that pin's bit of clr_pend.
- R5: A clear pulse in level mode has no effect; pend stays 1 while the pin is held low.
- R6: When a falling edge and a clear pulse for the same pin arrive in the same cycle, the edge wins and pend stays set.
- R7: While low_power is 1, a pin in edge mode behaves as level-sensitive: pend follows the inverted pin, and edges during that time leave no latched request.
- R8: Writing 0 to a sensitivity bit that holds 1 discards that pin's latched request. Switching back to edge mode afterwards shows pend 0.
- R9: rvec_valid is 1 while rst_n is low. It falls on exactly the second rising clock edge after rst_n is released and stays 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 2 | External active-low request pins; index 0 is pin A, index 1 is pin B |
| low_power | input | 1 | High while the system is in stop or wait mode |
| reg_wr | input | 1 | Write strobe for the sensitivity bits |
| reg_wdata | input | 2 | New sensitivity bits (1 = falling edge, 0 = low level) |
| clr_pend | input | 2 | Per-pin clear pulse for latched requests |
| reg_rdata | output | 4 | Status and control read view |
| pend | output | 2 | Pending request per pin |
| rvec_valid | output | 1 | Reset-vector-valid handshake |

## Verification
A latched request that failed to set, or failed to clear, shows on pend within three rising edges of the pin change or the clear pulse. It then persists until the next clear or mode write. An edge-detector history register left stale after a low-power exit can produce a spurious pending request. That error shows on pend one edge after low_power drops. A miscounted reset-vector hold shows as rvec_valid falling one edge early or late after reset release. It can also show as the signal rising again later.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic {
    SENS_LOW  = 1'b0,
    SENS_FALL = 1'b1
  } sens_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan
  import xirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lvl_i,
  input  sens_e sens_i,
  input  logic  low_power_i,
  input  logic  clr_i,
  input  logic  drop_i,
  output logic  pend_o
);
  logic prev_q;
  logic sticky_q;
  logic edge_mode;
  logic fall;

  assign edge_mode = (sens_i == SENS_FALL) && !low_power_i;
  assign fall      = prev_q && !lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl_i;
  end

  // An edge outranks a clear or a mode drop arriving in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sticky_q <= 1'b0;
    else if (fall && edge_mode) sticky_q <= 1'b1;
    else if (clr_i || drop_i)   sticky_q <= 1'b0;
  end

  assign pend_o = edge_mode ? sticky_q : !lvl_i;

  // R6 (and R4 set path): a captured edge is visible next cycle if still in edge mode
  a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && edge_mode) |=> (pend_o || !edge_mode));

  // R4: a latched request holds unless cleared, dropped or mode changes
  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && pend_o && !clr_i && !drop_i) |=> (pend_o || !edge_mode));
endmodule

// File: rtl/xirq_rvec.sv
module xirq_rvec #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rvec_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rvec_o <= 1'b1;
    end else if (rvec_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(HOLD - 1)) rvec_o <= 1'b0;
    end
  end

  // R9: held until the hold count is reached
  a_r9_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < CW'(HOLD)) |-> rvec_o);

  // R9: once dropped, never rises again until reset
  a_r9_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    !rvec_o |=> !rvec_o);
endmodule

// File: rtl/xirq_cond.sv
module xirq_cond
  import xirq_pkg::*;
#(
  parameter int NPIN   = 2,
  parameter int SYNC_N = 2,
  parameter int HOLD   = 2,
  localparam int RW    = 2 * NPIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] irq_n,
  input  logic            low_power,
  input  logic            reg_wr,
  input  logic [NPIN-1:0] reg_wdata,
  input  logic [NPIN-1:0] clr_pend,
  output logic [RW-1:0]   reg_rdata,
  output logic [NPIN-1:0] pend,
  output logic            rvec_valid
);
  logic [NPIN-1:0] lvl;
  logic [NPIN-1:0] sel_q;
  logic [NPIN-1:0] drop;

  xirq_sync #(.W(NPIN), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (irq_n),
    .q_o  (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (reg_wr) sel_q <= reg_wdata;
  end

  assign drop = {NPIN{reg_wr}} & ~reg_wdata & sel_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_chan
    xirq_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (lvl[i]),
      .sens_i     (sens_e'(sel_q[i])),
      .low_power_i(low_power),
      .clr_i      (clr_pend[i]),
      .drop_i     (drop[i]),
      .pend_o     (pend[i])
    );
  end

  assign reg_rdata = {lvl, sel_q};

  xirq_rvec #(.HOLD(HOLD)) u_rvec (
    .clk   (clk),
    .rst_n (rst_n),
    .rvec_o(rvec_valid)
  );

  // R7: in low power every request mirrors the inverted status level
  a_r7_lp_level: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (pend == ~reg_rdata[RW-1:NPIN]));

  // R3: level-mode pins mirror the inverted status level
  a_r3_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] == 1'b0) |-> (pend[0] == !reg_rdata[NPIN]));
endmodule

// File: tb/xirq_cond_tb.sv
module xirq_cond_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] irq_n = 2'b11;
  logic       low_power = 0;
  logic       reg_wr = 0;
  logic [1:0] reg_wdata = 0;
  logic [1:0] clr_pend = 0;
  logic [3:0] reg_rdata;
  logic [1:0] pend;
  logic       rvec_valid;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  xirq_cond u_dut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .low_power(low_power),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .clr_pend(clr_pend),
    .reg_rdata(reg_rdata), .pend(pend), .rvec_valid(rvec_valid)
  );

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] v);
    reg_wr = 1; reg_wdata = v;
    cyc(1);
    reg_wr = 0;
  endtask

  task automatic clr(logic [1:0] v);
    clr_pend = v;
    cyc(1);
    clr_pend = 0;
  endtask

  task automatic t_reset;
    rst_n = 0;
    cyc(2);
    chk("R9 valid in reset", {3'b0, rvec_valid}, 4'b1);
    rst_n = 1;
    cyc(1);
    chk("R9 valid after 1st edge", {3'b0, rvec_valid}, 4'b1);
    cyc(1);
    chk("R9 drops at 2nd edge", {3'b0, rvec_valid}, 4'b0);
    cyc(3);
    chk("R9 stays low", {3'b0, rvec_valid}, 4'b0);
    chk("R1 reset regs", reg_rdata, 4'b1100);
    chk("R1 reset pend", {2'b0, pend}, 4'b0);
  endtask

  task automatic t_status;
    irq_n = 2'b10;
    cyc(1);
    chk("R2 not yet visible", reg_rdata, 4'b1100);
    cyc(1);
    chk("R2 pin A low", reg_rdata, 4'b1000);
    irq_n = 2'b01;
    wr(2'b10);
    cyc(1);
    chk("R2 pin B low, sel B", reg_rdata, 4'b0110);
    wr(2'b00);
    irq_n = 2'b11;
    cyc(3);
  endtask

  task automatic t_level;
    irq_n = 2'b10;
    cyc(3);
    chk("R3 level pend", {2'b0, pend}, 4'b0001);
    clr(2'b01);
    chk("R5 clear ignored in level", {2'b0, pend}, 4'b0001);
    irq_n = 2'b11;
    cyc(3);
    chk("R3 not latched", {2'b0, pend}, 4'b0000);
  endtask

  task automatic t_edge;
    wr(2'b11);
    irq_n = 2'b01;
    cyc(3);
    irq_n = 2'b11;
    cyc(4);
    chk("R4 edge latched", {2'b0, pend}, 4'b0010);
    clr(2'b10);
    chk("R4 cleared", {2'b0, pend}, 4'b0000);
  endtask

  task automatic t_same_cycle;
    irq_n = 2'b10;
    cyc(2);
    clr_pend = 2'b01;
    cyc(1);
    clr_pend = 0;
    chk("R6 edge beats clear", {2'b0, pend}, 4'b0001);
    irq_n = 2'b11;
    cyc(3);
    clr(2'b01);
    chk("R6 later clear works", {2'b0, pend}, 4'b0000);
  endtask

  task automatic t_lowpower;
    low_power = 1;
    irq_n = 2'b10;
    cyc(3);
    chk("R7 forced level low", {2'b0, pend}, 4'b0001);
    irq_n = 2'b11;
    cyc(3);
    chk("R7 forced level released", {2'b0, pend}, 4'b0000);
    low_power = 0;
    cyc(1);
    chk("R7 no latch from low power", {2'b0, pend}, 4'b0000);
  endtask

  task automatic t_drop;
    irq_n = 2'b10;
    cyc(3);
    irq_n = 2'b11;
    cyc(3);
    chk("R8 setup latched", {2'b0, pend}, 4'b0001);
    wr(2'b10);
    wr(2'b11);
    chk("R8 drop discards latch", {2'b0, pend}, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_status();
    t_level();
    t_edge();
    t_same_cycle();
    t_lowpower();
    t_drop();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule